// File: doc/BRIEF.md
# Codec Converter Initialization Sequencer

This block governs the start-up of the digital sample paths in a stereo audio codec. It watches three power-enable bits: one for the left ADC, one for the right ADC and one for the DAC. When a path is switched on while the opposite direction is fully powered down, the block runs a fixed start-up interval. While that interval runs, the path's sample words on both channels are held at two's-complement zero. After the interval, samples pass through unchanged.

The interval is measured in sample periods, counted on a one-clock sample-rate strobe, and not in clock cycles. If the other direction is already powered, the newly enabled path needs no warm-up and passes data at once. A per-path busy flag tells downstream logic when the held-at-zero window is in force. An active-low power-down input, sampled on the clock, returns all state to idle.

Top module: `codec_init_seq`

## Requirements
- R1: While `pwr_down_n` is 0 at a rising clock edge, both busy flags are 0 after that edge and all four sample outputs equal their inputs.
- R2: A 0-to-1 change of `en_adc_l` or `en_adc_r` while `en_dac` is 0 sets `adc_busy` to 1 after the next rising clock edge.
- R3: A 0-to-1 change of `en_dac` while `en_adc_l` and `en_adc_r` are both 0 sets `dac_busy` to 1 after the next rising clock edge.
- R4: A busy flag stays 1 for exactly `INIT_TICKS` (default 1059) sampled `fs_tick` pulses, counted from the first edge after the start. It falls on the edge that samples the last of those pulses.
- R5: While `adc_busy` is 1, `adc_out_l` and `adc_out_r` are 0. Otherwise they equal `adc_in_l` and `adc_in_r`.
- R6: While `dac_busy` is 1, `dac_out_l` and `dac_out_r` are 0. Otherwise they equal `dac_in_l` and `dac_in_r`.
- R7: Enabling an ADC channel while `en_dac` is 1 leaves `adc_busy` at 0. Enabling the DAC while either ADC enable is 1 leaves `dac_busy` at 0.
- R8: If every enable bit of a path is 0 at a clock edge, that path's busy flag is 0 after the edge. A running interval is aborted.
- R9: Clock edges without `fs_tick` do not advance the interval.
- R10: An enable bit that is held at 1 never restarts an interval. Edges are detected against the value registered on the previous clock.
- R11: A fresh qualifying rising edge during a running ADC interval restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_down_n | input | 1 | Synchronous active-low power-down reset |
| fs_tick | input | 1 | One-clock pulse per sample period |
| en_adc_l | input | 1 | Left ADC power enable |
| en_adc_r | input | 1 | Right ADC power enable |
| en_dac | input | 1 | DAC power enable |
| adc_in_l | input | SAMPLE_W | Raw left ADC word |
| adc_in_r | input | SAMPLE_W | Raw right ADC word |
| dac_in_l | input | SAMPLE_W | Raw left DAC word |
| dac_in_r | input | SAMPLE_W | Raw right DAC word |
| adc_out_l | output | SAMPLE_W | Gated left ADC word |
| adc_out_r | output | SAMPLE_W | Gated right ADC word |
| dac_out_l | output | SAMPLE_W | Gated left DAC word |
| dac_out_r | output | SAMPLE_W | Gated DAC right word |
| adc_busy | output | 1 | ADC start-up interval in force |
| dac_busy | output | 1 | DAC start-up interval in force |

## Verification
Directed sequences turn on one ADC channel with the DAC off and count strobes up to the last one. This shows whether the interval is one sample period too short or too long. Further sequences cover enabling a path while the other direction is live, dropping enables mid-interval, and holding an enable high, which separate the skip, abort and no-retrigger rules. A long random run with sparse enable toggles, random strobes and random sample words is compared every cycle against a model in the bench. It catches wrong gating of either channel and strobes that are miscounted.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

    typedef enum logic {
        PATH_IDLE = 1'b0,
        PATH_WARM = 1'b1
    } path_state_t;

    typedef struct packed {
        logic adc_l;
        logic adc_r;
        logic dac;
    } pwr_en_t;

    function automatic logic went_high(input logic was, input logic now_v);
        return now_v & ~was;
    endfunction

endpackage

// File: rtl/codec_en_tracker.sv
module codec_en_tracker
    import codec_init_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pwr_en_t en,
    output logic    adc_start,
    output logic    dac_start
);
    pwr_en_t en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en;
    end

    always_comb begin
        adc_start = (went_high(en_q.adc_l, en.adc_l) | went_high(en_q.adc_r, en.adc_r))
                    & ~en.dac;
        dac_start = went_high(en_q.dac, en.dac) & ~en.adc_l & ~en.adc_r;
    end
endmodule

// File: rtl/codec_warm_timer.sv
module codec_warm_timer
    import codec_init_pkg::*;
#(
    parameter int INIT_TICKS = 1059
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic keep,
    output logic busy
);
    localparam int CW = $clog2(INIT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(INIT_TICKS - 1);

    path_state_t    state;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PATH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            state <= PATH_WARM;
            cnt   <= '0;
        end else if (state == PATH_WARM && !keep) begin
            state <= PATH_IDLE;
            cnt   <= '0;
        end else if (state == PATH_WARM && tick) begin
            if (cnt == LAST) begin
                state <= PATH_IDLE;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign busy = (state == PATH_WARM);
endmodule

// File: rtl/codec_sample_gate.sv
module codec_sample_gate #(
    parameter int SAMPLE_W = 16
) (
    input  logic                hold,
    input  logic [SAMPLE_W-1:0] in_l,
    input  logic [SAMPLE_W-1:0] in_r,
    output logic [SAMPLE_W-1:0] out_l,
    output logic [SAMPLE_W-1:0] out_r
);
    always_comb begin
        out_l = hold ? '0 : in_l;
        out_r = hold ? '0 : in_r;
    end
endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
    import codec_init_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int INIT_TICKS = 1059
) (
    input  logic                clk,
    input  logic                pwr_down_n,
    input  logic                fs_tick,
    input  logic                en_adc_l,
    input  logic                en_adc_r,
    input  logic                en_dac,
    input  logic [SAMPLE_W-1:0] adc_in_l,
    input  logic [SAMPLE_W-1:0] adc_in_r,
    input  logic [SAMPLE_W-1:0] dac_in_l,
    input  logic [SAMPLE_W-1:0] dac_in_r,
    output logic [SAMPLE_W-1:0] adc_out_l,
    output logic [SAMPLE_W-1:0] adc_out_r,
    output logic [SAMPLE_W-1:0] dac_out_l,
    output logic [SAMPLE_W-1:0] dac_out_r,
    output logic                adc_busy,
    output logic                dac_busy
);
    pwr_en_t en;
    logic    adc_start, dac_start;
    logic    adc_keep, dac_keep;

    assign en       = '{adc_l: en_adc_l, adc_r: en_adc_r, dac: en_dac};
    assign adc_keep = en_adc_l | en_adc_r;
    assign dac_keep = en_dac;

    codec_en_tracker u_track (
        .clk       (clk),
        .rst_n     (pwr_down_n),
        .en        (en),
        .adc_start (adc_start),
        .dac_start (dac_start)
    );

    codec_warm_timer #(.INIT_TICKS(INIT_TICKS)) u_adc_tmr (
        .clk   (clk),
        .rst_n (pwr_down_n),
        .tick  (fs_tick),
        .start (adc_start),
        .keep  (adc_keep),
        .busy  (adc_busy)
    );

    codec_warm_timer #(.INIT_TICKS(INIT_TICKS)) u_dac_tmr (
        .clk   (clk),
        .rst_n (pwr_down_n),
        .tick  (fs_tick),
        .start (dac_start),
        .keep  (dac_keep),
        .busy  (dac_busy)
    );

    codec_sample_gate #(.SAMPLE_W(SAMPLE_W)) u_adc_gate (
        .hold  (adc_busy),
        .in_l  (adc_in_l),
        .in_r  (adc_in_r),
        .out_l (adc_out_l),
        .out_r (adc_out_r)
    );

    codec_sample_gate #(.SAMPLE_W(SAMPLE_W)) u_dac_gate (
        .hold  (dac_busy),
        .in_l  (dac_in_l),
        .in_r  (dac_in_r),
        .out_l (dac_out_l),
        .out_r (dac_out_r)
    );
endmodule

// File: rtl/codec_init_chk.sv
module codec_init_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                pwr_down_n,
    input logic                fs_tick,
    input logic                en_adc_l,
    input logic                en_adc_r,
    input logic                en_dac,
    input logic [SAMPLE_W-1:0] adc_out_l,
    input logic [SAMPLE_W-1:0] adc_out_r,
    input logic [SAMPLE_W-1:0] dac_out_l,
    input logic [SAMPLE_W-1:0] dac_out_r,
    input logic                adc_busy,
    input logic                dac_busy
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !pwr_down_n |=> (!adc_busy && !dac_busy));

    // R2
    adc_start_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        (($rose(en_adc_l) || $rose(en_adc_r)) && !en_dac) |=> adc_busy);

    // R3
    dac_start_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        ($rose(en_dac) && !en_adc_l && !en_adc_r) |=> dac_busy);

    // R5
    adc_mute_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        adc_busy |-> (adc_out_l == '0 && adc_out_r == '0));

    // R6
    dac_mute_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        dac_busy |-> (dac_out_l == '0 && dac_out_r == '0));

    // R7
    adc_skip_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        (en_dac && !adc_busy) |=> !adc_busy);

    // R7
    dac_skip_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        ((en_adc_l || en_adc_r) && !dac_busy) |=> !dac_busy);

    // R8
    adc_abort_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        (!en_adc_l && !en_adc_r) |=> !adc_busy);

    // R8
    dac_abort_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        !en_dac |=> !dac_busy);

    // R9
    adc_hold_chk: assert property (@(posedge clk) disable iff (!pwr_down_n)
        (adc_busy && !fs_tick && (en_adc_l || en_adc_r)) |=> adc_busy);
endmodule

bind codec_init_seq codec_init_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .pwr_down_n (pwr_down_n),
    .fs_tick    (fs_tick),
    .en_adc_l   (en_adc_l),
    .en_adc_r   (en_adc_r),
    .en_dac     (en_dac),
    .adc_out_l  (adc_out_l),
    .adc_out_r  (adc_out_r),
    .dac_out_l  (dac_out_l),
    .dac_out_r  (dac_out_r),
    .adc_busy   (adc_busy),
    .dac_busy   (dac_busy)
);

// File: tb/sim_codec_init_seq.sv
`timescale 1ns/1ps
module sim_codec_init_seq;
    localparam int W = 16;
    localparam int N = 1059;

    logic         clk = 1'b0;
    logic         pwr_down_n = 1'b0;
    logic         fs_tick = 1'b0;
    logic         en_adc_l = 1'b0, en_adc_r = 1'b0, en_dac = 1'b0;
    logic [W-1:0] adc_in_l = '0, adc_in_r = '0, dac_in_l = '0, dac_in_r = '0;
    logic [W-1:0] adc_out_l, adc_out_r, dac_out_l, dac_out_r;
    logic         adc_busy, dac_busy;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    // bench model state
    bit m_ab = 0, m_db = 0;
    int m_ac = 0, m_dc = 0;
    bit p_l = 0, p_r = 0, p_d = 0;

    always #10 clk = ~clk;

    codec_init_seq #(.SAMPLE_W(W), .INIT_TICKS(N)) u0 (
        .clk(clk), .pwr_down_n(pwr_down_n), .fs_tick(fs_tick),
        .en_adc_l(en_adc_l), .en_adc_r(en_adc_r), .en_dac(en_dac),
        .adc_in_l(adc_in_l), .adc_in_r(adc_in_r),
        .dac_in_l(dac_in_l), .dac_in_r(dac_in_r),
        .adc_out_l(adc_out_l), .adc_out_r(adc_out_r),
        .dac_out_l(dac_out_l), .dac_out_r(dac_out_r),
        .adc_busy(adc_busy), .dac_busy(dac_busy)
    );

    function automatic logic [W-1:0] gated(input bit hold, input logic [W-1:0] v);
        return hold ? '0 : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the model by one edge using inputs present at that edge
    task automatic model_step();
        bit a_go, d_go;
        if (!pwr_down_n) begin
            m_ab = 0; m_db = 0; m_ac = 0; m_dc = 0;
            p_l = 0; p_r = 0; p_d = 0;
            return;
        end
        a_go = ((en_adc_l && !p_l) || (en_adc_r && !p_r)) && !en_dac;
        d_go = en_dac && !p_d && !en_adc_l && !en_adc_r;
        if (a_go) begin m_ab = 1; m_ac = 0; end
        else if (m_ab && !en_adc_l && !en_adc_r) begin m_ab = 0; m_ac = 0; end
        else if (m_ab && fs_tick) begin
            if (m_ac == N-1) begin m_ab = 0; m_ac = 0; end else m_ac++;
        end
        if (d_go) begin m_db = 1; m_dc = 0; end
        else if (m_db && !en_dac) begin m_db = 0; m_dc = 0; end
        else if (m_db && fs_tick) begin
            if (m_dc == N-1) begin m_db = 0; m_dc = 0; end else m_dc++;
        end
        p_l = en_adc_l; p_r = en_adc_r; p_d = en_dac;
    endtask

    // one clock: edge, then compare at the following falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(adc_busy == m_ab, "R4 adc_busy vs model", adc_busy, m_ab);
        chk(dac_busy == m_db, "R4 dac_busy vs model", dac_busy, m_db);
        chk(adc_out_l == gated(m_ab, adc_in_l), "R5 adc_out_l", adc_out_l, gated(m_ab, adc_in_l));
        chk(adc_out_r == gated(m_ab, adc_in_r), "R5 adc_out_r", adc_out_r, gated(m_ab, adc_in_r));
        chk(dac_out_l == gated(m_db, dac_in_l), "R6 dac_out_l", dac_out_l, gated(m_db, dac_in_l));
        chk(dac_out_r == gated(m_db, dac_in_r), "R6 dac_out_r", dac_out_r, gated(m_db, dac_in_r));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            fs_tick = 1'b1; cyc();
            fs_tick = 1'b0; cyc();
        end
    endtask

    task automatic rand_data();
        adc_in_l = W'($urandom); adc_in_r = W'($urandom);
        dac_in_l = W'($urandom); dac_in_r = W'($urandom);
    endtask

    initial begin
        #(20.0 * 190000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        rand_data();
        en_adc_l = 1; en_dac = 1;
        cyc(); cyc();
        // R1: reset state
        chk(!adc_busy && !dac_busy, "R1 busy in reset", {adc_busy, dac_busy}, 0);
        chk(adc_out_l == adc_in_l && dac_out_r == dac_in_r, "R1 pass-through in reset", adc_out_l, adc_in_l);
        en_adc_l = 0; en_dac = 0;
        pwr_down_n = 1; cyc();

        // R2, R5, R4: left ADC start with DAC off
        rand_data(); adc_in_l = 16'h7abc; adc_in_r = 16'h8001;
        en_adc_l = 1; cyc();
        chk(adc_busy == 1, "R2 adc_busy after enable", adc_busy, 1);
        chk(adc_out_l == 0 && adc_out_r == 0, "R5 adc outputs zero", adc_out_l, 0);
        // R9: no strobe, no progress
        repeat (3000) cyc();
        chk(adc_busy == 1, "R9 busy without strobes", adc_busy, 1);
        ticks(N - 1);
        chk(adc_busy == 1, "R4 busy after N-1 strobes", adc_busy, 1);
        fs_tick = 1; cyc(); fs_tick = 0;
        chk(adc_busy == 0, "R4 clear on strobe N", adc_busy, 0);
        chk(adc_out_r == adc_in_r, "R5 adc pass after interval", adc_out_r, adc_in_r);
        // R10: held enable does not retrigger
        ticks(20);
        chk(adc_busy == 0, "R10 no retrigger while held", adc_busy, 0);
        // R7: DAC enabled while ADC on, no DAC interval
        en_dac = 1; cyc();
        chk(dac_busy == 0, "R7 dac skip", dac_busy, 0);
        chk(dac_out_l == dac_in_l, "R7 dac pass", dac_out_l, dac_in_l);
        // R7: right ADC enabled while DAC on, no ADC interval
        en_adc_r = 1; cyc();
        chk(adc_busy == 0, "R7 adc skip", adc_busy, 0);

        // R3, R6, R8: DAC start then abort
        en_adc_l = 0; en_adc_r = 0; en_dac = 0; cyc(); cyc();
        en_dac = 1; cyc();
        chk(dac_busy == 1, "R3 dac_busy after enable", dac_busy, 1);
        chk(dac_out_l == 0 && dac_out_r == 0, "R6 dac outputs zero", dac_out_r, 0);
        ticks(100);
        en_dac = 0; cyc();
        chk(dac_busy == 0, "R8 dac abort", dac_busy, 0);
        chk(dac_out_l == dac_in_l, "R8 dac pass after abort", dac_out_l, dac_in_l);

        // R11: restart by second ADC channel
        en_adc_l = 1; cyc();
        ticks(600);
        en_adc_r = 1; cyc();
        ticks(N - 1);
        chk(adc_busy == 1, "R11 restarted count", adc_busy, 1);
        ticks(1);
        chk(adc_busy == 0, "R11 restarted interval ends", adc_busy, 0);

        // R1: reset mid interval
        en_adc_l = 0; en_adc_r = 0; cyc();
        en_adc_r = 1; cyc(); ticks(10);
        pwr_down_n = 0; cyc();
        chk(adc_busy == 0, "R1 reset aborts", adc_busy, 0);
        pwr_down_n = 1; en_adc_r = 0; cyc();

        // random phase
        for (int k = 0; k < 60000; k++) begin
            rand_data();
            fs_tick = ($urandom % 2) == 0;
            if ($urandom % 300 == 0) en_adc_l = ~en_adc_l;
            if ($urandom % 300 == 0) en_adc_r = ~en_adc_r;
            if ($urandom % 300 == 0) en_dac   = ~en_dac;
            pwr_down_n = ($urandom % 20000) != 0;
            cyc();
        end

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule